// File: doc/BRIEF.md
# Display command stream decoder

This block sits behind a host bulk-transfer link and turns its byte stream into writes to an 8-bit-addressed video register file. Every command opens with the prefix byte 0xAF, and an opcode byte follows it. A register-set command carries an address and a value. A copy command carries seven argument bytes. The decoder only parses the copy command, so that the stream stays aligned, and reports its fields on a one-cycle pulse.

A lock/unlock pair on address 0xFF lets software stage a whole set of timing writes into a shadow copy and then apply all of them in a single cycle. The outputs are the committed register values, decoded into named fields: colour depth, two 24-bit framebuffer bases, twelve 16-bit timing fields, the pixel clock and the blank mode.

Back-pressure rules:
- A byte transfers on a rising edge where both `in_valid` and `in_ready` are high.
- `in_ready` is low during reset and high from the first edge after reset, so the decoder never stalls the source.
- The source may drop `in_valid` between any two bytes, including bytes inside a command.

Top module: `vsd_decoder_top`

## Requirements
- R1: `in_ready` is high from the first clock edge after reset onward and stays high, and idle cycles between the bytes of a command do not change the result.
- R2: After reset, every register output, `copy_valid_o` and `err_o` read zero, and the registers are unlocked.
- R3: A register-set command (0xAF, 0x20, address, value) writes the value to the address. While unlocked, the new value shows at the outputs two cycles after the edge that accepts the value byte.
- R4: Writing 0x00 to address 0xFF locks. While locked, writes change no output. Writing 0xFF to address 0xFF unlocks and applies every staged write in the same cycle.
- R5: Bit 0 of address 0x00 drives `depth24_o`: 0 selects 16 bpp and 1 selects 24 bpp.
- R6: `base16_o` is {0x20, 0x21, 0x22} and `base8_o` is {0x26, 0x27, 0x28}, with the lowest address as the most significant byte.
- R7: Timing field i (0 to 11) in `timing_o[i]` is {addr 0x01+2i, addr 0x02+2i}, high byte first.
- R8: `pclk_o` (units of 5 kHz) takes its low byte from 0x1B and its high byte from 0x1C.
- R9: `blank_o` is the byte at address 0x1F.
- R10: A copy command (0xAF, 0x6A, then 7 bytes) pulses `copy_valid_o` for exactly one cycle. On that pulse, `copy_src_o` holds argument bytes 1 to 3 (MSB first), `copy_cnt_o` holds byte 4 and `copy_dst_o` holds bytes 5 to 7. It changes no register output.
- R11: A non-0xAF byte where a command should start, or an opcode other than 0x20 or 0x6A, sets `err_o`. `err_o` stays set until reset. Bytes are then dropped up to the next 0xAF, which is taken as a prefix.
- R12: Writes to addresses 0x29 to 0xFE, and writes of values other than 0x00 or 0xFF to 0xFF, change no output and no lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts a byte |
| depth24_o | output | 1 | Colour depth select, 1 = 24 bpp |
| base16_o | output | 24 | 16 bpp framebuffer base |
| base8_o | output | 24 | 8 bpp framebuffer base |
| timing_o | output | 12x16 | Timing fields, high byte at the lower address |
| pclk_o | output | 16 | Pixel clock in 5 kHz units |
| blank_o | output | 8 | Blank mode |
| copy_valid_o | output | 1 | One-cycle copy command pulse |
| copy_src_o | output | 24 | Copy source address |
| copy_cnt_o | output | 8 | Copy pixel count |
| copy_dst_o | output | 24 | Copy destination address |
| err_o | output | 1 | Sticky framing error |

## Verification
The main decode path is driven three ways: back-to-back register writes, writes with idle gaps inside a command, and writes staged under lock. The gaps show whether acceptance depends on `in_valid` alone. The staged writes show whether the shadow copy is kept apart from the active copy until commit. Multi-byte fields are loaded with distinct byte values, so a swapped byte order shows up, including the reversed order of the pixel clock pair. Corrupt prefixes and unknown opcodes are followed by a valid command, which shows whether resynchronisation works. Copy commands are scored against a queue of expected fields, which shows whether the arguments stay aligned.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_COUNT  = 41;            // addresses 0x00 .. 0x28
  localparam int NUM_TIM    = 12;
  localparam int TIM_W      = 2 * BYTE_W;
  localparam int ADDR_W     = 24;
  localparam int COPY_ARGS  = 7;
  localparam int ARG_CNT_W  = $clog2(COPY_ARGS + 1);

  localparam logic [7:0] CMD_PREFIX = 8'hAF;
  localparam logic [7:0] OP_REGSET  = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;

  localparam int ADR_DEPTH = 8'h00;
  localparam int ADR_TIM0  = 8'h01;
  localparam int ADR_PCLK  = 8'h1B;
  localparam int ADR_BLANK = 8'h1F;
  localparam int ADR_B16   = 8'h20;
  localparam int ADR_B8    = 8'h26;
  localparam logic [7:0] ADR_LOCK  = 8'hFF;
  localparam logic [7:0] VAL_LOCK  = 8'h00;
  localparam logic [7:0] VAL_OPEN  = 8'hFF;

  typedef enum logic [2:0] {
    PS_PREFIX,
    PS_OPCODE,
    PS_ADDR,
    PS_VALUE,
    PS_ARGS,
    PS_DISCARD
  } parse_state_e;

  typedef logic [REG_COUNT-1:0][BYTE_W-1:0] reg_bank_t;
endpackage

// File: rtl/vsd_parser.sv
module vsd_parser
  import vsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              copy_valid,
  output logic [ADDR_W-1:0] copy_src,
  output logic [7:0]        copy_cnt,
  output logic [ADDR_W-1:0] copy_dst,
  output logic              err
);
  localparam int SHIFT_W = COPY_ARGS * BYTE_W;

  parse_state_e         state_q;
  logic [7:0]           addr_q;
  logic [ARG_CNT_W-1:0] arg_cnt_q;
  logic [SHIFT_W-1:0]   shift_q;
  logic [SHIFT_W-1:0]   full_args;
  logic                 take;

  assign take      = in_valid && in_ready;
  assign full_args = {shift_q[SHIFT_W-BYTE_W-1:0], in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PS_PREFIX;
      in_ready   <= 1'b0;
      addr_q     <= '0;
      arg_cnt_q  <= '0;
      shift_q    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      copy_valid <= 1'b0;
      copy_src   <= '0;
      copy_cnt   <= '0;
      copy_dst   <= '0;
      err        <= 1'b0;
    end else begin
      in_ready   <= 1'b1;
      wr_en      <= 1'b0;
      copy_valid <= 1'b0;
      if (take) begin
        case (state_q)
          PS_PREFIX: begin
            if (in_data == CMD_PREFIX) state_q <= PS_OPCODE;
            else begin
              err     <= 1'b1;
              state_q <= PS_DISCARD;
            end
          end
          PS_OPCODE: begin
            if (in_data == OP_REGSET) state_q <= PS_ADDR;
            else if (in_data == OP_COPY) begin
              arg_cnt_q <= '0;
              state_q   <= PS_ARGS;
            end else begin
              err     <= 1'b1;
              state_q <= PS_DISCARD;
            end
          end
          PS_ADDR: begin
            addr_q  <= in_data;
            state_q <= PS_VALUE;
          end
          PS_VALUE: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= in_data;
            state_q <= PS_PREFIX;
          end
          PS_ARGS: begin
            shift_q   <= full_args;
            arg_cnt_q <= arg_cnt_q + 1'b1;
            if (arg_cnt_q == ARG_CNT_W'(COPY_ARGS - 1)) begin
              copy_valid <= 1'b1;
              copy_src   <= full_args[SHIFT_W-1 -: ADDR_W];
              copy_cnt   <= full_args[ADDR_W +: BYTE_W];
              copy_dst   <= full_args[ADDR_W-1:0];
              state_q    <= PS_PREFIX;
            end
          end
          default: begin
            if (in_data == CMD_PREFIX) state_q <= PS_OPCODE;
          end
        endcase
      end
    end
  end

  // R1: once ready, the decoder never withdraws it
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  // R10: the copy report is a single-cycle pulse
  a_r10_copy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |=> !copy_valid);
  // R11: the error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R3: a command takes at least four bytes, so two write strobes never touch
  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/vsd_regfile.sv
module vsd_regfile
  import vsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output reg_bank_t active_q
);
  reg_bank_t shadow_q;
  logic      locked_q;
  logic      is_lock_adr;
  logic      commit;
  logic      do_lock;

  assign is_lock_adr = wr_en && (wr_addr == ADR_LOCK);
  assign commit      = is_lock_adr && (wr_data == VAL_OPEN);
  assign do_lock     = is_lock_adr && (wr_data == VAL_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= 1'b0;
    else if (do_lock) locked_q <= 1'b1;
    else if (commit) locked_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (wr_en && (wr_addr == 8'(i))) begin
          shadow_q[i] <= wr_data;
          if (!locked_q) active_q[i] <= wr_data;
        end else if (commit) begin
          active_q[i] <= shadow_q[i];
        end
      end
    end
  end

  // R4: nothing reaches the active bank while locked, except the commit
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !commit) |=> $stable(active_q));
  // R4: the commit applies the whole shadow bank in one cycle
  a_r4_commit_all: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q == $past(shadow_q)));
  // R12: unmapped addresses leave both banks alone
  a_r12_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= 8'(REG_COUNT)) && (wr_addr != ADR_LOCK))
      |=> ($stable(active_q) && $stable(shadow_q) && $stable(locked_q)));
endmodule

// File: rtl/vsd_fields.sv
module vsd_fields
  import vsd_pkg::*;
(
  input  reg_bank_t                       bank,
  output logic                            depth24,
  output logic [ADDR_W-1:0]               base16,
  output logic [ADDR_W-1:0]               base8,
  output logic [NUM_TIM-1:0][TIM_W-1:0]   timing,
  output logic [TIM_W-1:0]                pclk,
  output logic [7:0]                      blank
);
  assign depth24 = bank[ADR_DEPTH][0];
  assign base16  = {bank[ADR_B16], bank[ADR_B16+1], bank[ADR_B16+2]};
  assign base8   = {bank[ADR_B8], bank[ADR_B8+1], bank[ADR_B8+2]};
  assign pclk    = {bank[ADR_PCLK+1], bank[ADR_PCLK]};
  assign blank   = bank[ADR_BLANK];

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    assign timing[g] = {bank[ADR_TIM0 + 2*g], bank[ADR_TIM0 + 2*g + 1]};
  end
endmodule

// File: rtl/vsd_decoder_top.sv
module vsd_decoder_top
  import vsd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [7:0]                    in_data,
  output logic                          in_ready,
  output logic                          depth24_o,
  output logic [ADDR_W-1:0]             base16_o,
  output logic [ADDR_W-1:0]             base8_o,
  output logic [NUM_TIM-1:0][TIM_W-1:0] timing_o,
  output logic [TIM_W-1:0]              pclk_o,
  output logic [7:0]                    blank_o,
  output logic                          copy_valid_o,
  output logic [ADDR_W-1:0]             copy_src_o,
  output logic [7:0]                    copy_cnt_o,
  output logic [ADDR_W-1:0]             copy_dst_o,
  output logic                          err_o
);
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  reg_bank_t  active;

  vsd_parser u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .copy_valid (copy_valid_o),
    .copy_src   (copy_src_o),
    .copy_cnt   (copy_cnt_o),
    .copy_dst   (copy_dst_o),
    .err        (err_o)
  );

  vsd_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .active_q (active)
  );

  vsd_fields u_fields (
    .bank    (active),
    .depth24 (depth24_o),
    .base16  (base16_o),
    .base8   (base8_o),
    .timing  (timing_o),
    .pclk    (pclk_o),
    .blank   (blank_o)
  );

  // R10: a copy command leaves the register outputs untouched
  a_r10_copy_no_regs: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid_o |-> ($stable(blank_o) && $stable(base16_o) && $stable(pclk_o)));
endmodule

// File: tb/vsd_decoder_top_tb_top.sv
`timescale 1ns/1ps
module vsd_decoder_top_tb_top;
  import vsd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic depth24_o;
  logic [23:0] base16_o, base8_o;
  logic [NUM_TIM-1:0][TIM_W-1:0] timing_o;
  logic [15:0] pclk_o;
  logic [7:0] blank_o;
  logic copy_valid_o;
  logic [23:0] copy_src_o, copy_dst_o;
  logic [7:0] copy_cnt_o;
  logic err_o;

  int checks = 0;
  int failures = 0;
  logic [55:0] exp_q[$];

  always #4 clk = ~clk;

  vsd_decoder_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .depth24_o(depth24_o), .base16_o(base16_o),
    .base8_o(base8_o), .timing_o(timing_o), .pclk_o(pclk_o),
    .blank_o(blank_o), .copy_valid_o(copy_valid_o), .copy_src_o(copy_src_o),
    .copy_cnt_o(copy_cnt_o), .copy_dst_o(copy_dst_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic regset(input logic [7:0] a, input logic [7:0] v);
    put(CMD_PREFIX); put(OP_REGSET); put(a); put(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic copy_cmd(input logic [23:0] s, input logic [7:0] c, input logic [23:0] d);
    exp_q.push_back({s, c, d});
    put(CMD_PREFIX); put(OP_COPY);
    put(s[23:16]); put(s[15:8]); put(s[7:0]); put(c);
    put(d[23:16]); put(d[15:8]); put(d[7:0]);
  endtask

  // scoreboard monitor for copy reports (R10)
  always @(negedge clk) begin
    if (rst_n && copy_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected copy pulse actual=%h expected=none",
                 {copy_src_o, copy_cnt_o, copy_dst_o});
      end else begin
        logic [55:0] e;
        e = exp_q.pop_front();
        checks++;
        if ({copy_src_o, copy_cnt_o, copy_dst_o} !== e) begin
          failures++;
          $display("FAIL R10 copy fields actual=%h expected=%h",
                   {copy_src_o, copy_cnt_o, copy_dst_o}, e);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R2 reset state
    chk("R2 depth", 32'(depth24_o), 0);
    chk("R2 base16", 32'(base16_o), 0);
    chk("R2 blank", 32'(blank_o), 0);
    chk("R2 err", 32'(err_o), 0);
    chk("R1 ready", 32'(in_ready), 1);

    // R5 / R3 unlocked write
    regset(8'h00, 8'h01); idle(3);
    chk("R5 depth24", 32'(depth24_o), 1);

    // R6 bases
    regset(8'h20, 8'h12); regset(8'h21, 8'h34); regset(8'h22, 8'h56);
    regset(8'h26, 8'hAB); regset(8'h27, 8'hCD); regset(8'h28, 8'hEF); idle(3);
    chk("R6 base16", 32'(base16_o), 32'h123456);
    chk("R6 base8", 32'(base8_o), 32'hABCDEF);

    // R7 timing fields
    regset(8'h01, 8'h12); regset(8'h02, 8'h34);
    regset(8'h17, 8'hBE); regset(8'h18, 8'hEF); idle(3);
    chk("R7 timing0", 32'(timing_o[0]), 32'h1234);
    chk("R7 timing11", 32'(timing_o[11]), 32'hBEEF);

    // R8 pixel clock, low byte first
    regset(8'h1B, 8'h34); regset(8'h1C, 8'h12); idle(3);
    chk("R8 pclk", 32'(pclk_o), 32'h1234);

    // R9 blank, and R1 with gaps inside a command
    put(CMD_PREFIX); idle(2); put(OP_REGSET); idle(1);
    put(8'h1F); idle(3); put(8'h05); idle(3);
    chk("R9 blank", 32'(blank_o), 32'h05);
    chk("R1 ready after gaps", 32'(in_ready), 1);

    // R4 lock staging, with R12 ignored writes while locked
    regset(8'hFF, 8'h00);
    regset(8'h1F, 8'h07); regset(8'h20, 8'h99);
    regset(8'h30, 8'h55); regset(8'hFF, 8'h42); idle(3);
    chk("R4 blank held", 32'(blank_o), 32'h05);
    chk("R4 base16 held", 32'(base16_o), 32'h123456);
    regset(8'hFF, 8'hFF); idle(3);
    chk("R4 blank commit", 32'(blank_o), 32'h07);
    chk("R4 base16 commit", 32'(base16_o), 32'h993456);

    // R12 odd value to 0xFF does not lock
    regset(8'hFF, 8'h42); regset(8'h1F, 8'h0B); idle(3);
    chk("R12 no lock", 32'(blank_o), 32'h0B);
    chk("R12 base8 unchanged", 32'(base8_o), 32'hABCDEF);

    // R10 copy commands
    copy_cmd(24'h010203, 8'h04, 24'h050607); idle(3);
    copy_cmd(24'hAFAF20, 8'h6A, 24'hFF00FF); idle(3);
    chk("R10 blank unchanged", 32'(blank_o), 32'h0B);
    regset(8'h1F, 8'h0C); idle(3);
    chk("R10 stream aligned", 32'(blank_o), 32'h0C);

    // R11 bad prefix, then resync
    chk("R11 err clear", 32'(err_o), 0);
    put(8'h11); idle(2);
    chk("R11 err set", 32'(err_o), 1);
    put(8'h22); put(8'h20); put(8'h1F); put(8'h01);
    regset(8'h1F, 8'h09); idle(3);
    chk("R11 resync", 32'(blank_o), 32'h09);
    chk("R11 err sticky", 32'(err_o), 1);

    // R11 unknown opcode drops the rest
    do_reset();
    chk("R2 err after reset", 32'(err_o), 0);
    put(CMD_PREFIX); put(8'h55); put(8'h20); put(8'h1F); put(8'h0A); idle(3);
    chk("R11 unknown opcode err", 32'(err_o), 1);
    chk("R11 dropped bytes", 32'(blank_o), 0);

    idle(4);
    chk("R10 queue drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule